// File: doc/BRIEF.md
# Sleep Mode and Clock-Gating Controller

This controller sits beside a small processor core and decides which clocks run. Software selects a low-power mode with a 3-bit code and arms an enable bit. When the core then issues its sleep strobe, the controller latches the mode. It then gates the CPU, flash, I/O, ADC and asynchronous-timer clock domains, and it switches off the main and timer oscillators that the chosen mode does not need.

While the core sleeps, the controller watches a vector of already-qualified wake requests. It filters that vector with a mask that belongs to the latched mode. It also watches a reset-wake input. A qualified wake first waits for the oscillator to settle. That wait is zero cycles when the oscillator kept running without standby, six cycles from the standby modes, and a configured number of cycles after a full oscillator stop. The CPU is then held for four more cycles. Finally the core is released with a one-cycle pulse that tells it to take the interrupt. A reset-wake skips the whole sequence and releases the core at once, with a pulse that asks for the reset vector.

All counting runs on the always-on clock `clk`, so the wait can be timed while the gated clocks are stopped. Every pin is a plain control or status signal; no data stream passes through the block.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: The controller leaves RUN for SLEEP only on a clock edge where `slp_strobe` and `slp_en` are both 1. `pm_state` encodes RUN=0, SLEEP=1, STARTUP=2, HALT=3.
- R2: Mode codes decode as follows: 000 Idle, 001 ADC-quiet, 010 Power-down, 011 Power-save, 110 Standby, 111 Extended Standby. The reserved codes 100 and 101 behave as Idle.
- R3: In SLEEP, the vector {cpu, flash, io, adc, asy, osc_main, osc_tmr} equals the following per mode: Idle 0011111, ADC-quiet 0001111, Power-down 0000000, Power-save 0000101, Standby 0000010, Extended Standby 0000111.
- R4: Codes 110 and 111 give Standby and Extended Standby only while `xtal_src` is 1. Otherwise they give Power-down and Power-save respectively.
- R5: `adc_autostart` pulses for exactly the first SLEEP cycle in two cases: entry into ADC-quiet, and entry into Idle (including the reserved codes) while `adc_enabled` is 1.
- R6: The `wake_req` bits are: 0 external/pin-change, 1 bus address match, 2 watchdog, 3 async timer event, 4 ADC done, 5 memory-write ready, 6 other I/O. The accepted sets are: Idle all bits; ADC-quiet bits 0-5; Power-down and Standby bits 0-2; Power-save and Extended Standby bits 0-3. Bits outside the accepted set leave the state in SLEEP.
- R7: After an accepted wake, STARTUP lasts D cycles, then HALT lasts 4 cycles, then RUN follows. D is 0 for Idle and ADC-quiet, 6 for the standby modes, and `startup_dly` for Power-down and Power-save.
- R8: `irq_take` is 1 for exactly the first RUN cycle that follows HALT after a wake request.
- R9: `rst_wake` in SLEEP, STARTUP or HALT gives RUN on the next cycle with `rst_vector` 1 and `irq_take` 0.
- R10: `cpu_run` is 1 only in RUN. In RUN all seven enables are 1. In HALT every enable except the CPU clock is 1.
- R11: `wake_req` and `rst_wake` have no effect while in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_en | input | 1 | Sleep arm bit |
| slp_mode | input | 3 | Requested mode code |
| slp_strobe | input | 1 | Sleep instruction strobe |
| xtal_src | input | 1 | Crystal source selected; permits the standby modes |
| adc_enabled | input | 1 | ADC is on; qualifies the Idle auto-start |
| startup_dly | input | DLY_W | Oscillator settle time in cycles |
| wake_req | input | 7 | Qualified wake requests |
| rst_wake | input | 1 | Reset arriving while not running |
| clk_cpu_en | output | 1 | CPU clock gate enable |
| clk_flash_en | output | 1 | Flash clock gate enable |
| clk_io_en | output | 1 | I/O clock gate enable |
| clk_adc_en | output | 1 | ADC clock gate enable |
| clk_asy_en | output | 1 | Async timer clock gate enable |
| osc_main_en | output | 1 | Main oscillator enable |
| osc_tmr_en | output | 1 | Timer oscillator enable |
| adc_autostart | output | 1 | Conversion start pulse on sleep entry |
| pm_state | output | 2 | Controller state |
| cpu_run | output | 1 | CPU may execute |
| irq_take | output | 1 | Take interrupt, resume after the sleep instruction |
| rst_vector | output | 1 | Restart from the reset vector |

## Verification
Each mode code, including the reserved codes and both settings of `xtal_src`, is entered once. This separates the clock-gating sets and the standby fallback. One wake source just outside the accepted set and one just inside it are then applied, which tells the masks of neighbouring modes apart. The number of cycles to RUN separates the three latency classes. Directed cases cover these points: entry blocked by a cleared enable, requests ignored in RUN, a reset-wake from SLEEP and from STARTUP, and a zero start-up delay.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam int NWAKE = 7;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_STARTUP = 2'd2,
    ST_HALT    = 2'd3
  } slp_state_e;

  typedef enum logic [2:0] {
    M_IDLE, M_ADCQ, M_PDOWN, M_PSAVE, M_STBY, M_XSTBY
  } eff_mode_e;

  typedef enum logic [1:0] {LAT_NONE, LAT_FAST, LAT_PROG} lat_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic asy;
  } clk_set_t;

  typedef struct packed {
    clk_set_t           clk;
    logic               osc_main;
    logic               osc_tmr;
    logic [NWAKE-1:0]   wake_mask;
    lat_e               lat;
  } profile_t;
endpackage

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_pkg::*;
(
  input  logic [2:0] code,
  input  logic       xtal_src,
  input  logic       adc_enabled,
  output eff_mode_e  mode,
  output logic       autostart
);
  always_comb begin
    case (code)
      3'b001:  mode = M_ADCQ;
      3'b010:  mode = M_PDOWN;
      3'b011:  mode = M_PSAVE;
      3'b110:  mode = xtal_src ? M_STBY  : M_PDOWN;
      3'b111:  mode = xtal_src ? M_XSTBY : M_PSAVE;
      default: mode = M_IDLE;
    endcase
    autostart = (mode == M_ADCQ) || ((mode == M_IDLE) && adc_enabled);
  end
endmodule

// File: rtl/sleep_profile.sv
module sleep_profile
  import sleep_pkg::*;
(
  input  eff_mode_e mode,
  output profile_t  prof
);
  always_comb begin
    prof = '0;
    case (mode)
      M_IDLE: begin
        prof.clk = 5'b00111; prof.osc_main = 1'b1; prof.osc_tmr = 1'b1;
        prof.wake_mask = 7'h7F; prof.lat = LAT_NONE;
      end
      M_ADCQ: begin
        prof.clk = 5'b00011; prof.osc_main = 1'b1; prof.osc_tmr = 1'b1;
        prof.wake_mask = 7'h3F; prof.lat = LAT_NONE;
      end
      M_PDOWN: begin
        prof.clk = 5'b00000; prof.osc_main = 1'b0; prof.osc_tmr = 1'b0;
        prof.wake_mask = 7'h07; prof.lat = LAT_PROG;
      end
      M_PSAVE: begin
        prof.clk = 5'b00001; prof.osc_main = 1'b0; prof.osc_tmr = 1'b1;
        prof.wake_mask = 7'h0F; prof.lat = LAT_PROG;
      end
      M_STBY: begin
        prof.clk = 5'b00000; prof.osc_main = 1'b1; prof.osc_tmr = 1'b0;
        prof.wake_mask = 7'h07; prof.lat = LAT_FAST;
      end
      default: begin
        prof.clk = 5'b00001; prof.osc_main = 1'b1; prof.osc_tmr = 1'b1;
        prof.wake_mask = 7'h0F; prof.lat = LAT_FAST;
      end
    endcase
  end
endmodule

// File: rtl/sleep_wake_timer.sv
module sleep_wake_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import sleep_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int FAST_CYC = 6,
  parameter int HALT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slp_en,
  input  logic [2:0]       slp_mode,
  input  logic             slp_strobe,
  input  logic             xtal_src,
  input  logic             adc_enabled,
  input  logic [DLY_W-1:0] startup_dly,
  input  logic [6:0]       wake_req,
  input  logic             rst_wake,
  output logic             clk_cpu_en,
  output logic             clk_flash_en,
  output logic             clk_io_en,
  output logic             clk_adc_en,
  output logic             clk_asy_en,
  output logic             osc_main_en,
  output logic             osc_tmr_en,
  output logic             adc_autostart,
  output logic [1:0]       pm_state,
  output logic             cpu_run,
  output logic             irq_take,
  output logic             rst_vector
);
  localparam logic [DLY_W-1:0] HALT_M1 = DLY_W'(HALT_CYC - 1);
  localparam logic [DLY_W-1:0] FAST_V  = DLY_W'(FAST_CYC);

  slp_state_e state, nxt;
  eff_mode_e  live_mode, mode_q, mode_d;
  profile_t   prof;
  logic       live_as, as_d, irq_d, rvec_d;
  logic       tm_load, tm_dec, tm_zero, wake_hit;
  logic [DLY_W-1:0] tm_val, lat_val;

  sleep_mode_decode u_dec (
    .code(slp_mode), .xtal_src(xtal_src), .adc_enabled(adc_enabled),
    .mode(live_mode), .autostart(live_as)
  );

  sleep_profile u_prof (.mode(mode_q), .prof(prof));

  sleep_wake_timer #(.W(DLY_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
    .dec(tm_dec), .zero(tm_zero)
  );

  assign wake_hit = |(wake_req & prof.wake_mask);

  always_comb begin
    case (prof.lat)
      LAT_NONE: lat_val = '0;
      LAT_FAST: lat_val = FAST_V;
      default:  lat_val = startup_dly;
    endcase
  end

  always_comb begin
    nxt = state; mode_d = mode_q; as_d = 1'b0; irq_d = 1'b0; rvec_d = 1'b0;
    tm_load = 1'b0; tm_val = '0; tm_dec = 1'b0;
    case (state)
      ST_RUN: if (slp_en && slp_strobe) begin
        nxt = ST_SLEEP; mode_d = live_mode; as_d = live_as;
      end
      ST_SLEEP: begin
        if (rst_wake) begin
          nxt = ST_RUN; rvec_d = 1'b1;
        end else if (wake_hit) begin
          tm_load = 1'b1;
          if (lat_val == '0) begin
            nxt = ST_HALT; tm_val = HALT_M1;
          end else begin
            nxt = ST_STARTUP; tm_val = lat_val - 1'b1;
          end
        end
      end
      ST_STARTUP: begin
        if (rst_wake) begin
          nxt = ST_RUN; rvec_d = 1'b1;
        end else if (tm_zero) begin
          nxt = ST_HALT; tm_load = 1'b1; tm_val = HALT_M1;
        end else tm_dec = 1'b1;
      end
      default: begin
        if (rst_wake) begin
          nxt = ST_RUN; rvec_d = 1'b1;
        end else if (tm_zero) begin
          nxt = ST_RUN; irq_d = 1'b1;
        end else tm_dec = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN; mode_q <= M_IDLE;
      adc_autostart <= 1'b0; irq_take <= 1'b0; rst_vector <= 1'b0;
    end else begin
      state <= nxt; mode_q <= mode_d;
      adc_autostart <= as_d; irq_take <= irq_d; rst_vector <= rvec_d;
    end
  end

  always_comb begin
    case (state)
      ST_RUN: begin
        {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en} = 5'b11111;
        osc_main_en = 1'b1; osc_tmr_en = 1'b1;
      end
      ST_HALT: begin
        {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en} = 5'b01111;
        osc_main_en = 1'b1; osc_tmr_en = 1'b1;
      end
      default: begin
        {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en} = prof.clk;
        osc_main_en = prof.osc_main || (state == ST_STARTUP);
        osc_tmr_en  = prof.osc_tmr;
      end
    endcase
  end

  assign pm_state = state;
  assign cpu_run  = (state == ST_RUN);
endmodule

// File: rtl/sleep_ctrl_checker.sv
module sleep_ctrl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       slp_en,
  input logic       slp_strobe,
  input logic       rst_wake,
  input logic [1:0] pm_state,
  input logic       cpu_run,
  input logic       clk_cpu_en,
  input logic       clk_flash_en,
  input logic       clk_io_en,
  input logic       clk_adc_en,
  input logic       clk_asy_en,
  input logic       osc_main_en,
  input logic       osc_tmr_en,
  input logic       adc_autostart,
  input logic       irq_take,
  input logic       rst_vector
);
  p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && slp_en && slp_strobe) |=> pm_state == 2'd1);

  p_no_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && !(slp_en && slp_strobe)) |=> pm_state == 2'd0);

  p_sleep_cpu_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd1) |-> (!clk_cpu_en && !clk_flash_en && !cpu_run));

  p_autostart_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_autostart |-> (pm_state == 2'd1 && $past(pm_state) == 2'd0));

  p_irq_after_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && $past(pm_state) == 2'd3 && !$past(rst_wake)) |-> irq_take);

  p_reset_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state != 2'd0 && rst_wake) |=> (pm_state == 2'd0 && rst_vector && !irq_take));

  p_run_clocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0) |-> (cpu_run && clk_cpu_en && clk_flash_en && clk_io_en &&
                            clk_adc_en && clk_asy_en && osc_main_en && osc_tmr_en));

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_take && rst_vector));
endmodule

bind pwr_sleep_ctrl sleep_ctrl_checker u_chk (.*);

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 16;
  localparam int SUD = 10;
  localparam int NV = 11;
  // {code[3], xtal, adc, clocks[7], autostart, bad_wake[7], good_wake[7], delay[5]}
  localparam logic [31:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b1, 7'h1F, 1'b1, 7'h00, 7'h40, 5'd0},
    {3'd0, 1'b0, 1'b0, 7'h1F, 1'b0, 7'h00, 7'h10, 5'd0},
    {3'd1, 1'b0, 1'b0, 7'h0F, 1'b1, 7'h40, 7'h10, 5'd0},
    {3'd2, 1'b0, 1'b1, 7'h00, 1'b0, 7'h78, 7'h01, 5'd10},
    {3'd3, 1'b0, 1'b0, 7'h05, 1'b0, 7'h70, 7'h08, 5'd10},
    {3'd6, 1'b1, 1'b0, 7'h02, 1'b0, 7'h78, 7'h04, 5'd6},
    {3'd7, 1'b1, 1'b0, 7'h07, 1'b0, 7'h70, 7'h08, 5'd6},
    {3'd6, 1'b0, 1'b0, 7'h00, 1'b0, 7'h78, 7'h02, 5'd10},
    {3'd7, 1'b0, 1'b0, 7'h05, 1'b0, 7'h70, 7'h08, 5'd10},
    {3'd4, 1'b0, 1'b1, 7'h1F, 1'b1, 7'h00, 7'h40, 5'd0},
    {3'd5, 1'b0, 1'b0, 7'h1F, 1'b0, 7'h00, 7'h20, 5'd0}
  };

  logic clk = 0, rst_n = 0;
  logic slp_en = 0, slp_strobe = 0, xtal_src = 0, adc_enabled = 0, rst_wake = 0;
  logic [2:0] slp_mode = 0;
  logic [DLY_W-1:0] startup_dly = DLY_W'(SUD);
  logic [6:0] wake_req = 0;
  logic clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en;
  logic osc_main_en, osc_tmr_en, adc_autostart, cpu_run, irq_take, rst_vector;
  logic [1:0] pm_state;
  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  pwr_sleep_ctrl #(.DLY_W(DLY_W)) i_pwr_sleep_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] gates();
    return {clk_cpu_en, clk_flash_en, clk_io_en, clk_adc_en, clk_asy_en, osc_main_en, osc_tmr_en};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic enter(input logic [2:0] code, input logic x, input logic a);
    @(negedge clk);
    slp_mode = code; xtal_src = x; adc_enabled = a; slp_en = 1; slp_strobe = 1;
    tick();
    slp_en = 0; slp_strobe = 0;
  endtask

  task automatic wake_and_count(input logic [6:0] w, output int n, output int nhalt,
                                output int runs);
    n = 0; nhalt = 0; runs = 0;
    @(negedge clk); wake_req = w;
    do begin
      tick(); n++;
      wake_req = 0;
      if (pm_state == 2'd3) nhalt++;
      if (pm_state != 2'd0 && cpu_run) runs++;
    end while (pm_state != 2'd0 && n < 100);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    int n, nh, rr;
    repeat (3) @(posedge clk);
    #1;
    // Reset state: R10
    chk("R10 reset state", pm_state, 0);
    chk("R10 reset gates", gates(), 7'h7F);
    chk("R10 reset cpu_run", cpu_run, 1);
    chk("R5 reset autostart", adc_autostart, 0);
    @(negedge clk); rst_n = 1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      enter(v[31:29], v[28], v[27]);
      chk("R1 enter sleep", pm_state, 1);
      chk("R3 R2 R4 gates in sleep", gates(), v[26:20]);
      chk("R5 autostart on entry", adc_autostart, v[19]);
      @(negedge clk); wake_req = v[18:12];
      tick();
      chk("R5 autostart single", adc_autostart, 0);
      tick();
      chk("R6 foreign wake ignored", pm_state, 1);
      wake_and_count(v[11:5], n, nh, rr);
      chk("R7 wake latency", n, int'(v[4:0]) + 5);
      chk("R7 halt length", nh, 4);
      chk("R10 cpu held", rr, 0);
      chk("R8 irq_take", irq_take, 1);
      chk("R9 no reset vector", rst_vector, 0);
      tick();
      chk("R8 irq_take single", irq_take, 0);
    end

    // R1: strobe with enable low
    @(negedge clk); slp_mode = 3'd2; slp_en = 0; slp_strobe = 1;
    tick(); slp_strobe = 0;
    chk("R1 strobe without enable", pm_state, 0);
    // R11: requests in RUN
    @(negedge clk); wake_req = 7'h7F; rst_wake = 1;
    tick(); wake_req = 0; rst_wake = 0;
    chk("R11 run ignores wake", pm_state, 0);
    chk("R11 no irq_take", irq_take, 0);
    chk("R11 no rst_vector", rst_vector, 0);
    // R9: reset-wake from sleep
    enter(3'd2, 0, 0);
    @(negedge clk); rst_wake = 1;
    tick(); rst_wake = 0;
    chk("R9 reset from sleep state", pm_state, 0);
    chk("R9 rst_vector", rst_vector, 1);
    chk("R9 no irq_take", irq_take, 0);
    // R9: reset-wake during startup
    enter(3'd3, 0, 0);
    @(negedge clk); wake_req = 7'h08;
    tick(); wake_req = 0;
    chk("R7 startup state", pm_state, 2);
    chk("R7 osc on in startup", osc_main_en, 1);
    tick(); tick();
    @(negedge clk); rst_wake = 1;
    tick(); rst_wake = 0;
    chk("R9 reset from startup", pm_state, 0);
    chk("R9 rst_vector startup", rst_vector, 1);
    // R7: zero start-up delay, R10 halt gates
    startup_dly = '0;
    enter(3'd2, 0, 0);
    @(negedge clk); wake_req = 7'h01;
    tick(); wake_req = 0;
    chk("R7 zero delay goes halt", pm_state, 3);
    chk("R10 halt gates", gates(), 7'h3F);
    tick(); tick(); tick(); tick();
    chk("R7 zero delay run", pm_state, 0);
    chk("R8 irq_take zero delay", irq_take, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule